// File: doc/BRIEF.md
# Grouped Peripheral Interrupt Expander

This block gathers a wide set of peripheral interrupt sources, organised as a number of groups with a fixed number of members each, and folds each group onto a single CPU interrupt line. Every source owns a sticky pending flag and an enable bit. Every group owns a gate bit that is set when the group forwards a request. While the gate is set, the group stays silent until software re-arms it. The default build has 12 groups of 8 sources each, giving 96 sources.

When the CPU takes a group's interrupt, it issues a vector fetch naming that group. One cycle later the block answers with the position of the highest-priority source that is both pending and enabled, and clears that source's flag. Software reaches flags, enables and gate bits through a single write port. A target code selects which of the three is written.

Top module: `grouped_irq_expander`

## Requirements
- R1: After synchronous reset, all flags, enables and gate bits are 0. `cpu_irq`, `vec_ack`, `vec_hit` and `vec_index` are all 0.
- R2: Source `src_in[g*GROUP_WIDTH+i]` being high at a clock edge sets the flag of group g, index i. The flag stays set after the source falls, even while its enable is 0.
- R3: A group forwards only when it has a flag whose enable is 1 and its gate bit is 0. Forwarding raises `cpu_irq[g]` for exactly one cycle, starting the cycle after the condition holds.
- R4: Forwarding sets the group's gate bit. No further `cpu_irq[g]` pulse occurs until a write with `wr_target`=2 clears it; that write clears the gate of every group g for which `wr_data[g]`=1. If requests are still pending, a new pulse follows the cycle after the clear.
- R5: Within a group, index 0 has the highest priority and index GROUP_WIDTH-1 the lowest. `vec_index` reports the winning index, 0-based.
- R6: `vec_req` high with `vec_group`=g produces `vec_ack` high in the next cycle only. `vec_hit` is 1 if group g had a pending, enabled source. In that case the winning flag is cleared and all other flags stay set. Without a hit, `vec_hit` is 0 and `vec_index` is 0.
- R7: A write with `wr_target`=1 replaces the enables of group `wr_group` with `wr_data[GROUP_WIDTH-1:0]` from the next cycle. A pending source whose enable is 0 is never selected by a fetch.
- R8: If a source is high in the same cycle that a fetch clears its flag, the flag remains set.
- R9: A write with `wr_target`=0 replaces the flags of group `wr_group` with `wr_data[GROUP_WIDTH-1:0]`. `wr_target`=3 writes nothing.
- R10: Groups are independent. Several groups may pulse their CPU lines in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_GROUPS*GROUP_WIDTH | Source request lines, group-major |
| wr_en | input | 1 | Register write strobe |
| wr_target | input | 2 | 0 flags, 1 enables, 2 gate clear, 3 none |
| wr_group | input | GSEL_W | Group addressed by flag/enable writes |
| wr_data | input | DATA_W | Write bits (per source, or per group for gate clear) |
| vec_req | input | 1 | Vector fetch request |
| vec_group | input | GSEL_W | Group being fetched |
| cpu_irq | output | NUM_GROUPS | One-cycle per-group CPU interrupt pulses |
| vec_ack | output | 1 | Fetch answer strobe |
| vec_hit | output | 1 | A source was selected |
| vec_index | output | IDX_W | Selected index within the group |

## Verification
The bench targets the gate: it parks a second request in a group whose gate is already set. A design that ignored the gate would pulse again before the software clear. One that lost the parked flag would stay silent after the clear. It raises a source on the very cycle a fetch clears that same flag; a design that lets the clear win would drop the request, so the follow-up pulse would never appear. It also fetches a group in which a higher-priority source is pending but disabled. It makes flag and enable writes and pulses several groups at once; a wrong mask, priority order or group decode would show up as a wrong index or a pulse on the wrong line.

// File: rtl/gie_pkg.sv
package gie_pkg;
    localparam int GRP_COUNT_DEF = 12;
    localparam int GRP_WIDTH_DEF = 8;

    typedef enum logic [1:0] {
        WT_FLAG   = 2'd0,
        WT_ENABLE = 2'd1,
        WT_ACK    = 2'd2,
        WT_NONE   = 2'd3
    } wr_target_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int idx_width(input int w);
        return (w > 1) ? $clog2(w) : 1;
    endfunction
endpackage

// File: rtl/gie_group_slice.sv
module gie_group_slice #(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [GW-1:0] src,
    input  logic          wr_flag,
    input  logic          wr_enable,
    input  logic          ack_clr,
    input  logic [GW-1:0] wr_bits,
    input  logic [GW-1:0] fetch_clr,
    output logic [GW-1:0] flags_o,
    output logic [GW-1:0] enables_o,
    output logic          ack_o,
    output logic          irq_o
);
    logic [GW-1:0] flag_q, flag_n, en_q;
    logic          ack_q, irq_q, fwd;

    // software write first, then fetch clear, then new pulses on top
    always_comb begin
        flag_n = flag_q;
        if (wr_flag) flag_n = wr_bits;
        flag_n = (flag_n & ~fetch_clr) | src;
    end

    assign fwd = (|(flag_q & en_q)) && !ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            en_q   <= '0;
            ack_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            flag_q <= flag_n;
            if (wr_enable) en_q <= wr_bits;
            irq_q <= fwd;
            if (fwd)          ack_q <= 1'b1;
            else if (ack_clr) ack_q <= 1'b0;
        end
    end

    assign flags_o   = flag_q;
    assign enables_o = en_q;
    assign ack_o     = ack_q;
    assign irq_o     = irq_q;
endmodule

// File: rtl/gie_first_pick.sv
module gie_first_pick #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  cand,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = |cand;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (cand[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/gie_vec_unit.sv
module gie_vec_unit #(
    parameter int NG  = 12,
    parameter int GW  = 8,
    parameter int GSW = 4,
    parameter int IW  = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req,
    input  logic [GSW-1:0]         grp,
    input  logic [NG-1:0][GW-1:0]  flags_all,
    input  logic [NG-1:0][GW-1:0]  en_all,
    output logic [NG-1:0][GW-1:0]  clr_all,
    output logic                   ack_o,
    output logic                   hit_o,
    output logic [IW-1:0]          idx_o
);
    logic [GW-1:0] cand;
    logic          pick_hit;
    logic [IW-1:0] pick_idx;

    always_comb begin
        cand = '0;
        for (int g = 0; g < NG; g++) begin
            if (int'(grp) == g) cand = flags_all[g] & en_all[g];
        end
    end

    gie_first_pick #(.W(GW), .IW(IW)) u_pick (
        .cand (cand),
        .hit  (pick_hit),
        .idx  (pick_idx)
    );

    always_comb begin
        for (int g = 0; g < NG; g++) begin
            clr_all[g] = (req && pick_hit && int'(grp) == g) ? (GW'(1) << pick_idx) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_o <= 1'b0;
            hit_o <= 1'b0;
            idx_o <= '0;
        end else begin
            ack_o <= req;
            hit_o <= req && pick_hit;
            idx_o <= (req && pick_hit) ? pick_idx : '0;
        end
    end
endmodule

// File: rtl/grouped_irq_expander.sv
module grouped_irq_expander #(
    parameter  int NUM_GROUPS  = gie_pkg::GRP_COUNT_DEF,
    parameter  int GROUP_WIDTH = gie_pkg::GRP_WIDTH_DEF,
    localparam int NUM_SRC     = NUM_GROUPS * GROUP_WIDTH,
    localparam int GSEL_W      = gie_pkg::idx_width(NUM_GROUPS),
    localparam int IDX_W       = gie_pkg::idx_width(GROUP_WIDTH),
    localparam int DATA_W      = gie_pkg::max_int(NUM_GROUPS, GROUP_WIDTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_SRC-1:0]    src_in,
    input  logic                  wr_en,
    input  logic [1:0]            wr_target,
    input  logic [GSEL_W-1:0]     wr_group,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  vec_req,
    input  logic [GSEL_W-1:0]     vec_group,
    output logic [NUM_GROUPS-1:0] cpu_irq,
    output logic                  vec_ack,
    output logic                  vec_hit,
    output logic [IDX_W-1:0]      vec_index
);
    import gie_pkg::*;

    logic [NUM_GROUPS-1:0][GROUP_WIDTH-1:0] flags_all, en_all, clr_all;
    logic [NUM_GROUPS-1:0]                  ack_vec;
    wr_target_e                             tgt;

    assign tgt = wr_target_e'(wr_target);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic sel;
        assign sel = wr_en && (int'(wr_group) == g);

        gie_group_slice #(.GW(GROUP_WIDTH)) u_slice (
            .clk       (clk),
            .rst       (rst),
            .src       (src_in[g*GROUP_WIDTH +: GROUP_WIDTH]),
            .wr_flag   (sel && tgt == WT_FLAG),
            .wr_enable (sel && tgt == WT_ENABLE),
            .ack_clr   (wr_en && tgt == WT_ACK && wr_data[g]),
            .wr_bits   (wr_data[GROUP_WIDTH-1:0]),
            .fetch_clr (clr_all[g]),
            .flags_o   (flags_all[g]),
            .enables_o (en_all[g]),
            .ack_o     (ack_vec[g]),
            .irq_o     (cpu_irq[g])
        );
    end

    gie_vec_unit #(
        .NG  (NUM_GROUPS),
        .GW  (GROUP_WIDTH),
        .GSW (GSEL_W),
        .IW  (IDX_W)
    ) u_vec (
        .clk       (clk),
        .rst       (rst),
        .req       (vec_req),
        .grp       (vec_group),
        .flags_all (flags_all),
        .en_all    (en_all),
        .clr_all   (clr_all),
        .ack_o     (vec_ack),
        .hit_o     (vec_hit),
        .idx_o     (vec_index)
    );
endmodule

// File: rtl/grouped_irq_expander_chk.sv
module grouped_irq_expander_chk #(
    parameter int NG = 12,
    parameter int GW = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NG-1:0]         cpu_irq,
    input logic                  vec_req,
    input logic                  vec_ack,
    input logic                  vec_hit,
    input logic [NG-1:0]         grp_ack,
    input logic [NG-1:0][GW-1:0] flags_all,
    input logic [NG-1:0][GW-1:0] en_all
);
    logic [NG-1:0] pend;
    always_comb begin
        for (int g = 0; g < NG; g++) pend[g] = |(flags_all[g] & en_all[g]);
    end

    // R3
    irq_needs_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_irq & ~$past(pend & ~grp_ack)) == '0);

    // R3
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_irq & $past(cpu_irq)) == '0);

    // R4
    irq_sets_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_irq & ~grp_ack) == '0);

    // R4
    gate_blocks_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_irq & $past(grp_ack)) == '0);

    // R6
    fetch_answer_chk: assert property (@(posedge clk) disable iff (rst)
        vec_req |=> vec_ack);

    // R6
    answer_has_request_chk: assert property (@(posedge clk) disable iff (rst)
        vec_ack |-> $past(vec_req));

    // R6
    hit_only_on_answer_chk: assert property (@(posedge clk) disable iff (rst)
        vec_hit |-> vec_ack);
endmodule

bind grouped_irq_expander grouped_irq_expander_chk #(
    .NG (NUM_GROUPS),
    .GW (GROUP_WIDTH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_irq   (cpu_irq),
    .vec_req   (vec_req),
    .vec_ack   (vec_ack),
    .vec_hit   (vec_hit),
    .grp_ack   (ack_vec),
    .flags_all (flags_all),
    .en_all    (en_all)
);

// File: tb/tb_grouped_irq_expander.sv
module tb_grouped_irq_expander;
    localparam int NG = 12;
    localparam int GW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [95:0]   src_in;
    logic          wr_en;
    logic [1:0]    wr_target;
    logic [3:0]    wr_group;
    logic [11:0]   wr_data;
    logic          vec_req;
    logic [3:0]    vec_group;
    logic [11:0]   cpu_irq;
    logic          vec_ack, vec_hit;
    logic [2:0]    vec_index;

    always #10 clk = ~clk;

    grouped_irq_expander dut (
        .clk(clk), .rst(rst), .src_in(src_in), .wr_en(wr_en),
        .wr_target(wr_target), .wr_group(wr_group), .wr_data(wr_data),
        .vec_req(vec_req), .vec_group(vec_group), .cpu_irq(cpu_irq),
        .vec_ack(vec_ack), .vec_hit(vec_hit), .vec_index(vec_index)
    );

    typedef struct {
        bit    is_vec;
        int    grp;
        bit    hit;
        int    idx;
        string tag;
    } ev_t;

    ev_t   sb[$];
    int    checks = 0;
    int    fails  = 0;
    string phase  = "R1";

    function automatic void exp_irq(int g, string tag);
        ev_t e;
        e.is_vec = 1'b0; e.grp = g; e.hit = 1'b0; e.idx = 0; e.tag = tag;
        sb.push_back(e);
    endfunction

    function automatic void exp_vec(int g, bit h, int i, string tag);
        ev_t e;
        e.is_vec = 1'b1; e.grp = g; e.hit = h; e.idx = i; e.tag = tag;
        sb.push_back(e);
    endfunction

    function automatic void observe(bit is_vec, int g, bit h, int i);
        ev_t e;
        checks++;
        if (sb.size() == 0) begin
            fails++;
            $display("FAIL %s: unexpected event vec=%0d grp=%0d hit=%0d idx=%0d, expected none",
                     phase, is_vec, g, h, i);
        end else begin
            e = sb.pop_front();
            if (e.is_vec != is_vec || e.grp != g || e.hit != h || e.idx != i) begin
                fails++;
                $display("FAIL %s: got vec=%0d grp=%0d hit=%0d idx=%0d, expected vec=%0d grp=%0d hit=%0d idx=%0d",
                         e.tag, is_vec, g, h, i, e.is_vec, e.grp, e.hit, e.idx);
            end
        end
    endfunction

    // monitor: samples away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            for (int g = 0; g < NG; g++) begin
                if (cpu_irq[g]) observe(1'b0, g, 1'b0, 0);
            end
            if (vec_ack) observe(1'b1, int'(vec_group_q), vec_hit, int'(vec_index));
        end
    end

    // group of the last fetch, held by the bench for reporting
    logic [3:0] vec_group_q = '0;
    always @(posedge clk) if (vec_req) vec_group_q <= vec_group;

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input int tgt, input int g, input int data);
        wr_en = 1'b1; wr_target = 2'(tgt); wr_group = 4'(g); wr_data = 12'(data);
        cyc();
        wr_en = 1'b0; wr_target = 2'd3; wr_group = '0; wr_data = '0;
    endtask

    task automatic pulse(input int g, input int mask);
        src_in[g*GW +: GW] = 8'(mask);
        cyc();
        src_in = '0;
    endtask

    task automatic fetch(input int g);
        vec_req = 1'b1; vec_group = 4'(g);
        cyc();
        vec_req = 1'b0; vec_group = '0;
    endtask

    task automatic drain(input string tag);
        repeat (6) cyc();
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d expected events missing, expected 0", tag, sb.size());
            sb.delete();
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; src_in = '0; wr_en = 1'b0; wr_target = 2'd3; wr_group = '0;
        wr_data = '0; vec_req = 1'b0; vec_group = '0;
        repeat (3) cyc();
        rst = 1'b0;

        // R1: reset state at the ports
        @(negedge clk);
        checks++;
        if (cpu_irq !== '0 || vec_ack !== 1'b0 || vec_hit !== 1'b0 || vec_index !== '0) begin
            fails++;
            $display("FAIL R1: irq=%h ack=%b hit=%b idx=%0d, expected all zero",
                     cpu_irq, vec_ack, vec_hit, vec_index);
        end
        cyc();

        // R1/R9: enables are 0, so pulsing everything raises nothing; then flag writes clear all
        phase = "R1";
        src_in = '1; cyc(); src_in = '0;
        for (int g = 0; g < NG; g++) wr(0, g, 0);
        wr(3, 0, 12'hfff);  // R9: target 3 writes nothing
        drain("R1");
        for (int g = 0; g < NG; g++) begin
            exp_vec(g, 1'b0, 0, "R9");
            fetch(g);
        end
        drain("R9");

        // R2/R3: enabled source forwards one pulse
        phase = "R3";
        wr(1, 0, 8'h04);
        exp_irq(0, "R3");
        pulse(0, 8'h04);
        drain("R3");
        exp_vec(0, 1'b1, 2, "R6");
        fetch(0);
        wr(2, 0, 12'h001);
        drain("R6");

        // R2: flag latched while disabled, forwarded once enabled (R7)
        phase = "R2";
        pulse(1, 8'h20);
        drain("R2");
        exp_irq(1, "R7");
        wr(1, 1, 8'h20);
        drain("R7");

        // R4: gate blocks a second request until cleared
        phase = "R4";
        wr(1, 1, 8'h28);
        pulse(1, 8'h08);
        drain("R4");
        exp_vec(1, 1'b1, 3, "R5");
        fetch(1);
        drain("R5");
        exp_irq(1, "R4");
        wr(2, 0, 12'h002);
        drain("R4");
        exp_vec(1, 1'b1, 5, "R6");
        fetch(1);
        wr(2, 0, 12'h002);
        drain("R6");

        // R6: fetch with nothing pending
        phase = "R6";
        exp_vec(2, 1'b0, 0, "R6");
        fetch(2);
        drain("R6");

        // R7: disabled source is never selected
        phase = "R7";
        wr(1, 3, 8'h40);
        exp_irq(3, "R7");
        pulse(3, 8'h41);
        drain("R7");
        exp_vec(3, 1'b1, 6, "R7");
        fetch(3);
        wr(1, 3, 8'h41);
        drain("R7");
        exp_irq(3, "R7");
        wr(2, 0, 12'h008);
        drain("R7");
        exp_vec(3, 1'b1, 0, "R7");
        fetch(3);
        wr(2, 0, 12'h008);
        drain("R7");

        // R8: new pulse beats clear-on-fetch
        phase = "R8";
        wr(1, 4, 8'h01);
        exp_irq(4, "R8");
        pulse(4, 8'h01);
        drain("R8");
        exp_vec(4, 1'b1, 0, "R8");
        src_in[32] = 1'b1; vec_req = 1'b1; vec_group = 4'd4;
        cyc();
        src_in = '0; vec_req = 1'b0; vec_group = '0;
        drain("R8");
        exp_irq(4, "R8");
        wr(2, 0, 12'h010);
        drain("R8");
        exp_vec(4, 1'b1, 0, "R8");
        fetch(4);
        wr(2, 0, 12'h010);
        drain("R8");

        // R9: flag write removes a pending source
        phase = "R9";
        wr(1, 5, 8'h03);
        exp_irq(5, "R9");
        pulse(5, 8'h03);
        drain("R9");
        wr(0, 5, 8'h02);
        exp_vec(5, 1'b1, 1, "R9");
        fetch(5);
        wr(2, 0, 12'h020);
        drain("R9");

        // R5: priority across a wide gap
        phase = "R5";
        wr(1, 7, 8'hff);
        exp_irq(7, "R5");
        pulse(7, 8'h90);
        drain("R5");
        exp_vec(7, 1'b1, 4, "R5");
        fetch(7);
        exp_irq(7, "R5");
        wr(2, 0, 12'h080);
        drain("R5");
        exp_vec(7, 1'b1, 7, "R5");
        fetch(7);
        wr(2, 0, 12'h080);
        drain("R5");

        // R10: two groups at once, both gates cleared by one write
        phase = "R10";
        wr(1, 6, 8'h80);
        wr(1, 11, 8'h01);
        exp_irq(6, "R10");
        exp_irq(11, "R10");
        src_in[6*GW+7] = 1'b1; src_in[11*GW] = 1'b1;
        cyc();
        src_in = '0;
        drain("R10");
        exp_irq(6, "R10");
        exp_irq(11, "R10");
        wr(2, 0, 12'h840);
        drain("R10");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule